// File: doc/BRIEF.md
# One-of-N Interrupt Target Selector

This block chooses exactly one destination core, out of `N_CORES`, for a single pending shared interrupt that is routed "to any one" core. The interrupt arrives with its group code and a two-bit class-target mask. Each core supplies live status: power state, sleep flag, an activity hint, a per-group enable bit, a per-group disable bit and a one-bit class. A distributor-wide enable per group completes the picture.

The selector offers the interrupt to one core through a request/accept handshake. Eligible cores whose activity hint is high are preferred over eligible cores sitting in retention. Within the preferred tier, a round-robin pointer spreads the load. The offer stays fixed until the core accepts it. If the offered core stops being eligible before it accepts, the offer is withdrawn with a one-cycle recall pulse and the selection runs again. When no core qualifies, a no-target flag stays raised for as long as the request is pending.

Top module: `one_of_n_sel`

## Requirements
- R1: Reset state: while `rst_ni` is low and after its release, `tgt_vld_o`, `no_tgt_o`, `recall_o` and `tgt_o` are all zero, and the round-robin pointer is 0.
- R2: Core c is eligible only when all of the following hold: `core_pwr_i[c]` is 1; `core_sleep_i[c]` is 0; the group is valid; `core_grp_en_i[c*3+g]` is 1; `core_dis_i[c*3+g]` is 0; `dist_grp_en_i[g]` is 1. Here g is the group code: 0 = Group 0, 1 = secure Group 1, 2 = non-secure Group 1. Code 3 makes no core eligible.
- R3: Class filter: core c passes only if `cls_mask_i[core_cls_i[c]]` is 1. The mask 2'b11 allows both classes and 2'b00 allows none.
- R4: If any eligible core has `core_act_i` high, the choice is made only among those cores. Otherwise it is made among the eligible cores with the hint low.
- R5: The activity hint never makes an ineligible core eligible, and it is ignored for a powered-down core.
- R6: Round robin: within the chosen tier, the search starts at the pointer index and wraps upward. When core k accepts, the pointer becomes (k+1) mod `N_CORES`.
- R7: A request seen in idle with at least one eligible core yields `tgt_vld_o` high on the next cycle. At that point `tgt_o` is one-hot, and `tgt_o` is zero whenever `tgt_vld_o` is low.
- R8: While offered, `tgt_o` holds steady until `ack_i` or a recall. `ack_i` while offered returns the block to idle on the next cycle.
- R9: A request seen in idle with no eligible core raises `no_tgt_o` on the next cycle. The flag stays high while the request is pending and none qualifies, and it is never high together with `tgt_vld_o`.
- R10: If the offered core is ineligible in a cycle without `ack_i`, the next cycle shows `recall_o` high for one cycle with `tgt_vld_o` low. The cycle after that carries a fresh selection. `ack_i` in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Interrupt pending, held until accepted |
| grp_i | input | 2 | Interrupt group code |
| cls_mask_i | input | 2 | Allowed core classes |
| core_pwr_i | input | N_CORES | Core powered up |
| core_sleep_i | input | N_CORES | Core sleep flag |
| core_act_i | input | N_CORES | Activity hint, low in retention |
| core_grp_en_i | input | N_CORES*3 | Per-core group enables, bit c*3+g |
| core_dis_i | input | N_CORES*3 | Per-core one-of-N group disables, bit c*3+g |
| core_cls_i | input | N_CORES | Core class |
| dist_grp_en_i | input | 3 | Distributor group enables |
| ack_i | input | 1 | Offered core accepts |
| tgt_o | output | N_CORES | One-hot target |
| tgt_vld_o | output | 1 | Target offered |
| no_tgt_o | output | 1 | Request pending with no eligible core |
| recall_o | output | 1 | Offer withdrawn, reselecting |

## Verification
Directed patterns separate the qualification terms. They clear one eligibility condition at a time, so a dropped term in the eligibility product shows up as a wrong core. They set all hints low, hint only a powered-down core, or hint a single core away from the pointer, which tells tier preference apart from plain round robin. Back-to-back accepts and a class mask of 01 against split classes expose pointer-update and mask-indexing mistakes. Random status vectors, compared with a bench model, mix all terms together, and a recall case plus a simultaneous accept-and-disable case pin down the retarget timing.

// File: rtl/one_of_n_pkg.sv
package one_of_n_pkg;
  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned GRP_W   = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  typedef enum logic {
    ST_IDLE,
    ST_OFFER
  } sel_state_e;
endpackage

// File: rtl/one_of_n_elig.sv
module one_of_n_elig
  import one_of_n_pkg::*;
#(
  parameter int unsigned N_CORES = 8
) (
  input  logic [GRP_W-1:0]           grp_i,
  input  logic [1:0]                 cls_mask_i,
  input  logic [N_CORES-1:0]         core_pwr_i,
  input  logic [N_CORES-1:0]         core_sleep_i,
  input  logic [N_CORES*NUM_GRP-1:0] core_grp_en_i,
  input  logic [N_CORES*NUM_GRP-1:0] core_dis_i,
  input  logic [N_CORES-1:0]         core_cls_i,
  input  logic [NUM_GRP-1:0]         dist_grp_en_i,
  output logic [N_CORES-1:0]         elig_o
);
  logic grp_ok;
  logic dist_ok;

  assign grp_ok  = (grp_i != GRP_RSVD);
  assign dist_ok = grp_ok && dist_grp_en_i[grp_i];

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [NUM_GRP-1:0] en_c;
    logic [NUM_GRP-1:0] dis_c;
    logic               grp_pass;
    assign en_c     = core_grp_en_i[c*NUM_GRP +: NUM_GRP];
    assign dis_c    = core_dis_i[c*NUM_GRP +: NUM_GRP];
    assign grp_pass = dist_ok && en_c[grp_i] && !dis_c[grp_i];
    assign elig_o[c] = core_pwr_i[c] && !core_sleep_i[c] && grp_pass
                       && cls_mask_i[core_cls_i[c]];
  end
endmodule

// File: rtl/one_of_n_rr_pick.sv
module one_of_n_rr_pick #(
  parameter int unsigned N_CORES = 8,
  localparam int unsigned IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic [N_CORES-1:0] cand_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic [N_CORES-1:0] pick_oh_o,
  output logic [IDX_W-1:0]   pick_idx_o,
  output logic               any_o
);
  logic [N_CORES-1:0] upper;
  logic               hit_up;
  logic               hit_all;
  logic [IDX_W-1:0]   idx_up;
  logic [IDX_W-1:0]   idx_all;

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      upper[i] = cand_i[i] && (IDX_W'(i) >= ptr_i);
    end
  end

  // lowest set bit at or above the pointer, else lowest overall
  always_comb begin
    hit_up  = 1'b0;
    hit_all = 1'b0;
    idx_up  = '0;
    idx_all = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (upper[i]) begin
        hit_up = 1'b1;
        idx_up = IDX_W'(i);
      end
      if (cand_i[i]) begin
        hit_all = 1'b1;
        idx_all = IDX_W'(i);
      end
    end
  end

  assign any_o      = hit_all;
  assign pick_idx_o = hit_up ? idx_up : idx_all;

  always_comb begin
    pick_oh_o = '0;
    if (hit_all) pick_oh_o[pick_idx_o] = 1'b1;
  end
endmodule

// File: rtl/one_of_n_sel.sv
module one_of_n_sel
  import one_of_n_pkg::*;
#(
  parameter int unsigned N_CORES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [1:0]                 grp_i,
  input  logic [1:0]                 cls_mask_i,
  input  logic [N_CORES-1:0]         core_pwr_i,
  input  logic [N_CORES-1:0]         core_sleep_i,
  input  logic [N_CORES-1:0]         core_act_i,
  input  logic [N_CORES*3-1:0]       core_grp_en_i,
  input  logic [N_CORES*3-1:0]       core_dis_i,
  input  logic [N_CORES-1:0]         core_cls_i,
  input  logic [2:0]                 dist_grp_en_i,
  input  logic                       ack_i,
  output logic [N_CORES-1:0]         tgt_o,
  output logic                       tgt_vld_o,
  output logic                       no_tgt_o,
  output logic                       recall_o
);
  localparam int unsigned IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CORES - 1);

  logic [N_CORES-1:0] elig;
  logic [N_CORES-1:0] act_elig;
  logic [N_CORES-1:0] cand;
  logic [N_CORES-1:0] pick_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;

  sel_state_e         state_q;
  logic [N_CORES-1:0] tgt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   ptr_q;
  logic               no_tgt_q;
  logic               recall_q;
  logic               tgt_still_ok;

  one_of_n_elig #(.N_CORES(N_CORES)) i_elig (
    .grp_i         (grp_i),
    .cls_mask_i    (cls_mask_i),
    .core_pwr_i    (core_pwr_i),
    .core_sleep_i  (core_sleep_i),
    .core_grp_en_i (core_grp_en_i),
    .core_dis_i    (core_dis_i),
    .core_cls_i    (core_cls_i),
    .dist_grp_en_i (dist_grp_en_i),
    .elig_o        (elig)
  );

  // active tier wins; retention tier only as fallback
  assign act_elig = elig & core_act_i;
  assign cand     = (|act_elig) ? act_elig : elig;

  one_of_n_rr_pick #(.N_CORES(N_CORES)) i_pick (
    .cand_i     (cand),
    .ptr_i      (ptr_q),
    .pick_oh_o  (pick_oh),
    .pick_idx_o (pick_idx),
    .any_o      (pick_any)
  );

  assign tgt_still_ok = |(tgt_q & elig);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tgt_q    <= '0;
      idx_q    <= '0;
      ptr_q    <= '0;
      no_tgt_q <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      recall_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i && pick_any) begin
            state_q  <= ST_OFFER;
            tgt_q    <= pick_oh;
            idx_q    <= pick_idx;
            no_tgt_q <= 1'b0;
          end else begin
            no_tgt_q <= req_i;
          end
        end
        ST_OFFER: begin
          if (ack_i) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            ptr_q   <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          end else if (!req_i) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
          end else if (!tgt_still_ok) begin
            state_q  <= ST_IDLE;
            tgt_q    <= '0;
            recall_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tgt_o     = tgt_q;
  assign tgt_vld_o = (state_q == ST_OFFER);
  assign no_tgt_o  = no_tgt_q;
  assign recall_o  = recall_q;
endmodule

// File: rtl/one_of_n_sel_chk.sv
module one_of_n_sel_chk #(
  parameter int unsigned N_CORES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [N_CORES-1:0] core_pwr_i,
  input logic [N_CORES-1:0] core_sleep_i,
  input logic               ack_i,
  input logic [N_CORES-1:0] tgt_o,
  input logic               tgt_vld_o,
  input logic               no_tgt_o,
  input logic               recall_o
);
  AST_TGT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_vld_o |-> $countones(tgt_o) == 1); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_vld_o |-> tgt_o == '0); // R7
  AST_TGT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_vld_o && !ack_i |=> !tgt_vld_o || $stable(tgt_o)); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(no_tgt_o && tgt_vld_o)); // R9
  AST_RECALL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> !tgt_vld_o); // R10
  AST_RECALL_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_vld_o && req_i && !ack_i && (tgt_o & core_sleep_i) != '0 |=> recall_o); // R10
  AST_PICK_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_vld_o) |-> ($past(core_sleep_i) & tgt_o) == '0
                         && ($past(core_pwr_i) & tgt_o) != '0); // R2
endmodule

bind one_of_n_sel one_of_n_sel_chk #(.N_CORES(N_CORES)) i_one_of_n_sel_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .core_pwr_i   (core_pwr_i),
  .core_sleep_i (core_sleep_i),
  .ack_i        (ack_i),
  .tgt_o        (tgt_o),
  .tgt_vld_o    (tgt_vld_o),
  .no_tgt_o     (no_tgt_o),
  .recall_o     (recall_o)
);

// File: tb/test_one_of_n_sel.sv
module test_one_of_n_sel;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           req_i = 1'b0;
  logic [1:0]     grp_i;
  logic [1:0]     cls_mask_i;
  logic [N-1:0]   core_pwr_i, core_sleep_i, core_act_i, core_cls_i;
  logic [N*3-1:0] core_grp_en_i, core_dis_i;
  logic [2:0]     dist_grp_en_i;
  logic           ack_i = 1'b0;
  logic [N-1:0]   tgt_o;
  logic           tgt_vld_o, no_tgt_o, recall_o;

  int n_run = 0;
  int n_fail = 0;
  int ptr_m = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  one_of_n_sel #(.N_CORES(N)) i_one_of_n_sel (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_pick(int p);
    logic [N-1:0] ok;
    logic [N-1:0] hot;
    int g = int'(grp_i);
    for (int c = 0; c < N; c++) begin
      ok[c] = core_pwr_i[c] && !core_sleep_i[c] && (g < 3)
              && core_grp_en_i[c*3+g] && !core_dis_i[c*3+g]
              && dist_grp_en_i[g] && cls_mask_i[core_cls_i[c]];
    end
    hot = ok & core_act_i;
    if (hot != '0) ok = hot;
    for (int i = 0; i < N; i++) begin
      if (ok[(p + i) % N]) return (p + i) % N;
    end
    return -1;
  endfunction

  task automatic all_ok();
    grp_i = 2'd0; cls_mask_i = 2'b11;
    core_pwr_i = '1; core_sleep_i = '0; core_act_i = '1; core_cls_i = '0;
    core_grp_en_i = '1; core_dis_i = '0; dist_grp_en_i = 3'b111;
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  // request, check offer, accept; called at a negedge with idle DUT
  task automatic offer(string req);
    int e;
    e = model_pick(ptr_m);
    req_i = 1'b1;
    cyc();
    if (e >= 0) begin
      chk({req, " vld"}, 32'(tgt_vld_o), 32'd1);
      chk({req, " tgt"}, 32'(tgt_o), 32'(1 << e));
      chk({req, " no_tgt"}, 32'(no_tgt_o), 32'd0);
      ack_i = 1'b1;
      cyc();
      ack_i = 1'b0; req_i = 1'b0;
      ptr_m = (e + 1) % N;
      chk({req, " R8 idle after ack"}, 32'(tgt_vld_o), 32'd0);
    end else begin
      chk({req, " R9 vld"}, 32'(tgt_vld_o), 32'd0);
      chk({req, " R9 no_tgt"}, 32'(no_tgt_o), 32'd1);
      req_i = 1'b0;
      cyc();
      chk({req, " R9 no_tgt clears"}, 32'(no_tgt_o), 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int e1, e2;
    void'($urandom(32'hC0FFEE));
    all_ok();
    @(negedge clk_i);
    chk("R1 vld", 32'(tgt_vld_o), 0);
    chk("R1 tgt", 32'(tgt_o), 0);
    chk("R1 flags", 32'({no_tgt_o, recall_o}), 0);
    rst_ni = 1'b1;
    cyc();
    chk("R1 after release", 32'({tgt_vld_o, no_tgt_o, recall_o}), 0);

    offer("R6 first from ptr0");
    offer("R6 advance");
    offer("R6 advance again");

    core_act_i = 8'b0010_0000;
    offer("R4 lone active core");
    core_act_i = '0;
    offer("R4 all retention");
    core_pwr_i = 8'b1111_0111; core_act_i = 8'b0000_1000;
    offer("R5 powered-down hint ignored");
    all_ok();
    core_sleep_i = 8'b1011_1111;
    offer("R2 sleep");
    all_ok();
    grp_i = 2'd1; dist_grp_en_i = 3'b101;
    offer("R2 distributor disable");
    grp_i = 2'd3; dist_grp_en_i = 3'b111;
    offer("R2 reserved group");
    grp_i = 2'd2; core_grp_en_i = '0; core_grp_en_i[4*3+2] = 1'b1;
    offer("R2 core group enable");
    all_ok();
    grp_i = 2'd1;
    for (int c = 0; c < N; c++) if (c != 2) core_dis_i[c*3+1] = 1'b1;
    offer("R2 disable bits");
    all_ok();
    core_cls_i = 8'h0F; cls_mask_i = 2'b01;
    offer("R3 class0 only");
    cls_mask_i = 2'b10;
    offer("R3 class1 only");
    cls_mask_i = 2'b00;
    offer("R3 empty mask");

    // R9 -> becomes eligible while pending
    all_ok(); dist_grp_en_i = 3'b000;
    req_i = 1'b1; cyc();
    chk("R9 raised", 32'(no_tgt_o), 1);
    cyc();
    chk("R9 held", 32'(no_tgt_o), 1);
    dist_grp_en_i = 3'b111;
    e1 = model_pick(ptr_m);
    cyc();
    chk("R9 then offer", 32'({no_tgt_o, tgt_vld_o}), 1);
    chk("R9 then tgt", 32'(tgt_o), 32'(1 << e1));
    // R8 hold while other inputs change
    core_act_i = 8'h00; core_cls_i = 8'hFF;
    cyc();
    chk("R8 stable", 32'(tgt_o), 32'(1 << e1));
    // R10 recall
    core_dis_i[e1*3+0] = 1'b1;
    cyc();
    chk("R10 recall pulse", 32'({recall_o, tgt_vld_o}), 32'b10);
    e2 = model_pick(ptr_m);
    cyc();
    chk("R10 recall one cycle", 32'(recall_o), 0);
    chk("R10 reselect", 32'(tgt_o), 32'(1 << e2));
    // R10 ack wins over ineligibility
    core_sleep_i[e2] = 1'b1; ack_i = 1'b1;
    cyc();
    ack_i = 1'b0; req_i = 1'b0;
    chk("R10 ack precedence", 32'({recall_o, tgt_vld_o}), 0);
    ptr_m = (e2 + 1) % N;
    all_ok();
    offer("R6 pointer after ack-precedence");

    for (int it = 0; it < 400; it++) begin
      grp_i = 2'($urandom_range(0, 3));
      cls_mask_i = 2'($urandom);
      core_pwr_i = N'($urandom | $urandom);
      core_sleep_i = N'($urandom & $urandom & $urandom);
      core_act_i = N'($urandom & $urandom);
      core_cls_i = N'($urandom);
      core_grp_en_i = (N*3)'($urandom | $urandom);
      core_dis_i = (N*3)'($urandom & $urandom & $urandom);
      dist_grp_en_i = 3'($urandom | $urandom);
      offer("R4 R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule